// File: doc/BRIEF.md
# E1 Timeslot-16 Signaling Inserter

This block sits in the transmit path of an E1 interface and places per-channel ABCD signaling into timeslot 16. An external framer supplies, with each byte of the stream, a strobe, the timeslot number (0 to 31) and the frame number within a 16-frame multiframe (0 to 15). Every byte comes out one clock later. Most bytes leave unchanged. When insertion is enabled, the timeslot-16 byte is replaced. In frame 0 it carries the multiframe alignment pattern. In frames 1 to 15 it carries two channels' signaling nibbles.

Signaling words are written through a small register port. Each word has 4 bits, with A in bit 3 and D in bit 0. Slot k, for k from 1 to 15, holds channel k. Slot k+16, for k from 1 to 15, holds channel k+15. Writes go into a shadow bank. That bank is copied to the active bank at each frame start, so a single timeslot-16 byte never mixes old and new data.

Insertion needs two conditions. The global mode input must select channel-associated signaling (value 0), and bit 16 of a per-timeslot source mask must be 1. If either condition fails, timeslot 16 passes through unchanged, like every other timeslot.

Top module: `e1_ts16_cas_inserter`

## Requirements
- R1: After reset, `out_byte` is 0x00 and `out_valid` is 0 until the first strobed byte has been registered.
- R2: `out_valid` is high exactly one cycle after each cycle with `in_valid` high. For every strobed byte whose `in_ts` is not 16, `out_byte` in that later cycle equals `in_byte`. In cycles without a strobe, `out_byte` holds its last value.
- R3: With insertion enabled, a timeslot-16 byte in frame n (n from 1 to 15) has bits 7..4 equal to the active word of slot n. Bit 7 is A and bit 4 is D. Bit 7 is the first bit on the line.
- R4: With insertion enabled, a timeslot-16 byte in frame n (n from 1 to 15) has bits 3..0 equal to the active word of slot n+16, which is channel n+15.
- R5: With insertion enabled, the timeslot-16 byte of frame 0 is 0x0F. That is the alignment nibble 0000 followed by 1111, with the spare bits at 1.
- R6: When `ccs_mode` is 1, the timeslot-16 byte passes through unchanged.
- R7: When `ts_src_mask[16]` is 0, the timeslot-16 byte passes through unchanged. The other 31 mask bits have no effect on any output.
- R8: Writes addressed to slot 0 or slot 16 change no stored word.
- R9: A write becomes visible in the active bank at the next strobed byte with `in_ts` = 0. A write made in the same cycle as such a byte waits for the following one.
- R10: After reset, every slot holds 4'b1101 until it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte strobe from the framer |
| in_frame | input | 4 | Frame number within the multiframe |
| in_ts | input | 5 | Timeslot number of the strobed byte |
| in_byte | input | 8 | Incoming byte |
| ccs_mode | input | 1 | 1 = common-channel mode; 0 = allow signaling insertion |
| ts_src_mask | input | 32 | Per-timeslot source select; bit 16 gates insertion |
| wr_en | input | 1 | Signaling word write strobe |
| wr_slot | input | 5 | Slot addressed by the write |
| wr_abcd | input | 4 | ABCD word, A in bit 3 |
| out_byte | output | 8 | Outgoing byte |
| out_valid | output | 1 | Strobe for `out_byte` |

## Verification
Each strobed input byte produces its output exactly one clock later. The bench works out the expected byte as it drives the input on a falling edge. It then compares that value at the next falling edge, after the single register stage has loaded it. Signaling writes follow a two-step timing. A write reaches the shadow bank at the clock edge where it is driven. It only shows on the line at a timeslot-16 byte that comes after a later frame-start byte. The bench model copies its shadow array into its active array when it drives each timeslot-0 byte. It does this before applying any write made in that same cycle.

// File: rtl/e1cas_pkg.sv
package e1cas_pkg;
    typedef enum logic [1:0] {
        KIND_PASS = 2'd0,
        KIND_MFAS = 2'd1,
        KIND_SIG  = 2'd2
    } ts16_kind_e;

    localparam logic [3:0] MFAS_NIBBLE  = 4'b0000;
    localparam logic [3:0] SPARE_NIBBLE = 4'b1111;
    localparam logic [3:0] IDLE_ABCD    = 4'b1101;
endpackage

// File: rtl/e1cas_sig_store.sv
module e1cas_sig_store #(
    parameter int NUM_SLOTS = 32,
    parameter int NIB_W     = 4,
    parameter int SKIP_SLOT = 16,
    parameter logic [NIB_W-1:0] RESET_WORD = 4'b1101,
    localparam int AW = $clog2(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_slot,
    input  logic [NIB_W-1:0] wr_abcd,
    input  logic             commit,
    input  logic [AW-1:0]    rd_slot_hi,
    input  logic [AW-1:0]    rd_slot_lo,
    output logic [NIB_W-1:0] rd_hi,
    output logic [NIB_W-1:0] rd_lo
);
    typedef logic [NUM_SLOTS-1:0][NIB_W-1:0] bank_t;

    typedef struct packed {
        bank_t shadow;
        bank_t active;
    } store_t;

    store_t st_d, st_q;
    logic [NUM_SLOTS-1:0] hit;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_hit
        if (i == 0 || i == SKIP_SLOT) begin : g_skip
            assign hit[i] = 1'b0;
        end else begin : g_live
            assign hit[i] = wr_en && (wr_slot == AW'(i));
        end
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (hit[i]) st_d.shadow[i] = wr_abcd;
        end
        if (commit) st_d.active = st_q.shadow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.shadow <= {NUM_SLOTS{RESET_WORD}};
            st_q.active <= {NUM_SLOTS{RESET_WORD}};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_hi = st_q.active[rd_slot_hi];
    assign rd_lo = st_q.active[rd_slot_lo];

    // R8
    skip_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_slot == '0 || wr_slot == AW'(SKIP_SLOT))) |=> $stable(st_q.shadow));

    // R9
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(st_q.active));

    // R9
    commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (st_q.active == $past(st_q.shadow)));
endmodule

// File: rtl/e1cas_ts16_build.sv
module e1cas_ts16_build
    import e1cas_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int NIB_W     = 4,
    parameter int FR_W      = 4,
    parameter int TS_W      = 5,
    parameter int SIG_TS    = 16,
    localparam int AW     = $clog2(NUM_SLOTS),
    localparam int BYTE_W = 2 * NIB_W,
    localparam int HALF   = NUM_SLOTS / 2
) (
    input  logic [FR_W-1:0]      frame,
    input  logic [TS_W-1:0]      ts,
    input  logic                 ccs_mode,
    input  logic [NUM_SLOTS-1:0] ts_src_mask,
    input  logic [BYTE_W-1:0]    byte_in,
    input  logic [NIB_W-1:0]     word_hi,
    input  logic [NIB_W-1:0]     word_lo,
    output logic [AW-1:0]        slot_hi,
    output logic [AW-1:0]        slot_lo,
    output ts16_kind_e           kind,
    output logic [BYTE_W-1:0]    byte_out
);
    logic insert_ok;

    assign slot_hi   = AW'(frame);
    assign slot_lo   = AW'(frame) + AW'(HALF);
    assign insert_ok = (ts == TS_W'(SIG_TS)) && !ccs_mode && ts_src_mask[SIG_TS];

    always_comb begin
        if (!insert_ok)        kind = KIND_PASS;
        else if (frame == '0)  kind = KIND_MFAS;
        else                   kind = KIND_SIG;
    end

    always_comb begin
        unique case (kind)
            KIND_MFAS: byte_out = {MFAS_NIBBLE, SPARE_NIBBLE};
            KIND_SIG:  byte_out = {word_hi, word_lo};
            default:   byte_out = byte_in;
        endcase
    end
endmodule

// File: rtl/e1_ts16_cas_inserter.sv
module e1_ts16_cas_inserter
    import e1cas_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int NIB_W     = 4,
    parameter int FR_W      = 4,
    parameter int SIG_TS    = 16,
    localparam int TS_W   = $clog2(NUM_SLOTS),
    localparam int BYTE_W = 2 * NIB_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [FR_W-1:0]      in_frame,
    input  logic [TS_W-1:0]      in_ts,
    input  logic [BYTE_W-1:0]    in_byte,
    input  logic                 ccs_mode,
    input  logic [NUM_SLOTS-1:0] ts_src_mask,
    input  logic                 wr_en,
    input  logic [TS_W-1:0]      wr_slot,
    input  logic [NIB_W-1:0]     wr_abcd,
    output logic [BYTE_W-1:0]    out_byte,
    output logic                 out_valid
);
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              vld;
    } out_t;

    out_t st_d, st_q;

    logic [TS_W-1:0]   slot_hi, slot_lo;
    logic [NIB_W-1:0]  word_hi, word_lo;
    logic [BYTE_W-1:0] built;
    ts16_kind_e        kind;
    logic              frame_start;

    assign frame_start = in_valid && (in_ts == '0);

    e1cas_sig_store #(
        .NUM_SLOTS (NUM_SLOTS),
        .NIB_W     (NIB_W),
        .SKIP_SLOT (SIG_TS),
        .RESET_WORD(IDLE_ABCD)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_slot   (wr_slot),
        .wr_abcd   (wr_abcd),
        .commit    (frame_start),
        .rd_slot_hi(slot_hi),
        .rd_slot_lo(slot_lo),
        .rd_hi     (word_hi),
        .rd_lo     (word_lo)
    );

    e1cas_ts16_build #(
        .NUM_SLOTS(NUM_SLOTS),
        .NIB_W    (NIB_W),
        .FR_W     (FR_W),
        .TS_W     (TS_W),
        .SIG_TS   (SIG_TS)
    ) u_build (
        .frame      (in_frame),
        .ts         (in_ts),
        .ccs_mode   (ccs_mode),
        .ts_src_mask(ts_src_mask),
        .byte_in    (in_byte),
        .word_hi    (word_hi),
        .word_lo    (word_lo),
        .slot_hi    (slot_hi),
        .slot_lo    (slot_lo),
        .kind       (kind),
        .byte_out   (built)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) st_d.data = built;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_byte  = st_q.data;
    assign out_valid = st_q.vld;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    other_ts_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ts != TS_W'(SIG_TS)) |=> (out_byte == $past(in_byte)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_byte)));

    // R6
    ccs_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ccs_mode) |=> (out_byte == $past(in_byte)));

    // R7
    mask_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ts_src_mask[SIG_TS]) |=> (out_byte == $past(in_byte)));

    // R5
    mfas_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ts == TS_W'(SIG_TS) && !ccs_mode && ts_src_mask[SIG_TS]
         && in_frame == '0) |=> (out_byte == {MFAS_NIBBLE, SPARE_NIBBLE}));
endmodule

// File: tb/e1_ts16_cas_inserter_tb.sv
module e1_ts16_cas_inserter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_frame = '0;
    logic [4:0]  in_ts = '0;
    logic [7:0]  in_byte = '0;
    logic        ccs_mode = 1'b0;
    logic [31:0] ts_src_mask = 32'h0001_0000;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_slot = '0;
    logic [3:0]  wr_abcd = '0;
    logic [7:0]  out_byte;
    logic        out_valid;

    always #2 clk = ~clk;

    e1_ts16_cas_inserter u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_frame(in_frame),
        .in_ts(in_ts), .in_byte(in_byte), .ccs_mode(ccs_mode),
        .ts_src_mask(ts_src_mask), .wr_en(wr_en), .wr_slot(wr_slot),
        .wr_abcd(wr_abcd), .out_byte(out_byte), .out_valid(out_valid)
    );

    int total = 0;
    int bad = 0;
    logic [3:0] m_shadow [32];
    logic [3:0] m_active [32];
    logic [7:0] exp_data = '0;
    logic       exp_vld = 1'b0;
    bit         have_exp = 1'b0;
    string      exp_tag = "R1";
    string      sig_tag = "R3 R4";
    bit         done = 1'b0;

    function automatic logic [7:0] model_byte(input logic [3:0] fr, input logic [4:0] ts,
                                              input logic [7:0] din, input logic ccs,
                                              input logic [31:0] mask, output string tag);
        if (ts != 5'd16) begin tag = "R2"; return din; end
        if (ccs) begin tag = "R6"; return din; end
        if (!mask[16]) begin tag = "R7"; return din; end
        if (fr == 4'd0) begin tag = "R5"; return 8'h0F; end
        tag = sig_tag;
        return {m_active[fr], m_active[5'(fr) + 5'd16]};
    endfunction

    task automatic check_prev();
        if (!have_exp) return;
        total++;
        if (out_valid !== exp_vld || out_byte !== exp_data) begin
            bad++;
            $display("FAIL %s: got valid=%0b byte=%02h, expected valid=%0b byte=%02h",
                     exp_tag, out_valid, out_byte, exp_vld, exp_data);
        end
    endtask

    task automatic cycle(input logic v, input logic [3:0] fr, input logic [4:0] ts,
                         input logic [7:0] din, input logic w, input logic [4:0] ws,
                         input logic [3:0] wd, input logic ccs, input logic [31:0] mask);
        string t;
        @(negedge clk);
        check_prev();
        in_valid = v; in_frame = fr; in_ts = ts; in_byte = din;
        wr_en = w; wr_slot = ws; wr_abcd = wd; ccs_mode = ccs; ts_src_mask = mask;
        if (v && ts == 5'd0) for (int i = 0; i < 32; i++) m_active[i] = m_shadow[i];
        if (w && ws != 5'd0 && ws != 5'd16) m_shadow[ws] = wd;
        exp_vld = v;
        if (v) begin
            exp_data = model_byte(fr, ts, din, ccs, mask, t);
            exp_tag = t;
        end else begin
            exp_tag = "R2";
        end
        have_exp = 1'b1;
    endtask

    // mode: 0 random writes, 1 no writes, 2 boundary-timed writes,
    //       3 writes to unused slots, 4 random enables
    task automatic run_mf(input int mode);
        for (int fr = 0; fr < 16; fr++) begin
            for (int ts = 0; ts < 32; ts++) begin
                logic        w = 1'b0;
                logic [4:0]  ws = 5'($urandom_range(31));
                logic [3:0]  wd = 4'($urandom);
                logic        ccs = 1'b0;
                logic [31:0] mask = $urandom | 32'h0001_0000;
                if ($urandom_range(99) < 15)
                    cycle(1'b0, 4'(fr), 5'(ts), 8'($urandom), 1'b0, '0, '0, 1'b0, mask);
                case (mode)
                    0: w = ($urandom_range(99) < 10);
                    2: begin
                        if (fr == 3 && ts == 0) begin w = 1'b1; ws = 5'd3; wd = ~m_shadow[3]; end
                        if (fr == 3 && ts == 0) w = 1'b1;
                        if (fr == 4 && ts == 20) begin w = 1'b1; ws = 5'd21; wd = ~m_shadow[21]; end
                    end
                    3: begin
                        w = ($urandom_range(99) < 30);
                        ws = ($urandom_range(1) == 0) ? 5'd0 : 5'd16;
                    end
                    4: begin
                        w = ($urandom_range(99) < 5);
                        ccs = ($urandom_range(99) < 25);
                        if ($urandom_range(99) < 30) mask[16] = 1'b0;
                    end
                    default: w = 1'b0;
                endcase
                cycle(1'b1, 4'(fr), 5'(ts), 8'($urandom), w, ws, wd, ccs, mask);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) begin m_shadow[i] = 4'b1101; m_active[i] = 4'b1101; end
        repeat (3) @(negedge clk);
        // R1: reset state
        total++;
        if (out_byte !== 8'h00 || out_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1: got valid=%0b byte=%02h, expected valid=0 byte=00", out_valid, out_byte);
        end
        rst_n = 1'b1;
        total++;
        @(negedge clk);
        if (out_byte !== 8'h00 || out_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1: got valid=%0b byte=%02h after release, expected 0/00", out_valid, out_byte);
        end
        sig_tag = "R10";
        run_mf(1);
        sig_tag = "R3 R4";
        for (int k = 0; k < 4; k++) run_mf(0);
        sig_tag = "R9";
        run_mf(2);
        run_mf(1);
        sig_tag = "R8";
        run_mf(3);
        run_mf(1);
        sig_tag = "R3 R4";
        for (int k = 0; k < 3; k++) run_mf(4);
        for (int k = 0; k < 2; k++) run_mf(0);
        cycle(1'b0, '0, '0, '0, 1'b0, '0, '0, 1'b0, 32'h0001_0000);
        @(negedge clk);
        check_prev();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got no completion, expected end of run");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule